// File: doc/BRIEF.md
# Shared Interrupt Controller with Command Word

This block collects a parameterised group of shared interrupt inputs and steers each one to a single processor core. Every source has its own sense setting. It can be level-sensitive or edge-latched, active high or active low. A dual-edge option makes any transition latch the source, whatever its polarity. Each source also has an enable bit and a route field that names the core it belongs to. For each core the block drives a request line and the number of the lowest-numbered source that is pending, enabled and routed to that core.

A single write-only command word does two jobs, selected by its top bit. When the top bit is set, the word raises the named source by software; this is how one core interrupts another. When the top bit is clear, the word acknowledges the named source by clearing its latched pending bit. All configuration sits behind a simple strobe-based register port. That port also holds a read-only word that reports the source and core counts.

Top module: `shint_hub`

Register map (8-bit address, 32-bit data):
- 0x00 identity word, read-only: bits [7:0] hold NUM_SRC/8-1 and bits [23:16] hold NUM_CORE-1.
- 0x01 command word, write-only, reads as zero: bit 31 selects raise (1) or acknowledge (0), and bits [7:0] give the source number.
- 0x80+n sense word for source n: bit 0 is polarity (1 = active high), bit 1 is trigger (1 = edge), bit 2 is dual-edge, bit 3 is enable (1 = may be reported), and bits [8 +: CORE_W] give the target core. CORE_W is clog2(NUM_CORE), and at least 1.
- Writes to any other address have no effect.

## Requirements
- R1: A command write with bit 31 = 1 latches source wdata[7:0] as pending, in either trigger mode. The latched bit stays set after the input goes inactive.
- R2: A command write with bit 31 = 0 clears the latched pending bit of source wdata[7:0]. A level source whose input is still active stays pending.
- R3: In level mode a source is pending while its input matches the polarity bit. In edge mode it latches on the transition into the active state and stays latched after the input returns.
- R4: With trigger = edge and dual-edge = 1, both rising and falling transitions latch the source, and the polarity bit has no effect.
- R5: After reset every sense word reads 0x00000001 (level, active high, disabled, core 0). All request lines are low and every reported index equals NUM_SRC.
- R6: A source qualifies for core c when it is pending, enabled and routed to c. Each core reports its lowest-numbered qualifying source with its request line high. With none qualifying, the request line is low and the index equals NUM_SRC.
- R7: Each source goes to exactly the core named by its route field. Rewriting the field removes it from its old core. A route value of NUM_CORE or more sends it to no core.
- R8: The identity word reads (NUM_SRC/8-1) in bits [7:0] and (NUM_CORE-1) in bits [23:16], with the other bits zero.
- R9: A read returns its data on rdata one clock after rd_en. A sense word reads back exactly the fields written to it, and the command address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Raw shared interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| core_req | output | NUM_CORE | Per-core request lines |
| core_idx | output | NUM_CORE*IDX_W | Per-core reported source index, core 0 in the low bits |

## Verification
The bench builds the block with NUM_SRC = 24 and NUM_CORE = 3. A source count that is not a power of two puts the idle index value (24) away from any wrap point of the 5-bit index. With three cores the 2-bit route field has a spare value (3), which makes the route-to-nowhere case reachable. The three cores also let one source be moved between cores while the other cores are observed.

// File: rtl/shint_pkg.sv
package shint_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_IDENT = 8'h00;
  localparam logic [ADDR_W-1:0] A_CMD   = 8'h01;

  localparam int B_POL  = 0;
  localparam int B_TRIG = 1;
  localparam int B_DUAL = 2;
  localparam int B_EN   = 3;
  localparam int B_ROUTE = 8;
  localparam int B_RAISE = 31;

  function automatic logic [DATA_W-1:0] ident_word(int nsrc, int ncore);
    logic [DATA_W-1:0] w;
    w = '0;
    w[7:0]   = 8'(nsrc / 8 - 1);
    w[23:16] = 8'(ncore - 1);
    return w;
  endfunction

endpackage

// File: rtl/shint_regs.sv
module shint_regs
  import shint_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2,
  parameter int CORE_W   = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_SRC-1:0]         cfg_pol,
  output logic [NUM_SRC-1:0]         cfg_trig,
  output logic [NUM_SRC-1:0]         cfg_dual,
  output logic [NUM_SRC-1:0]         cfg_en,
  output logic [NUM_SRC*CORE_W-1:0]  cfg_route,
  output logic [NUM_SRC-1:0]         cmd_set,
  output logic [NUM_SRC-1:0]         cmd_clr
);

  logic is_src_space;
  logic is_cmd;
  logic [DATA_W-1:0] rd_word;
  logic unused_bits;

  assign is_src_space = addr[ADDR_W-1];
  assign is_cmd       = wr_en && (addr == A_CMD);
  assign unused_bits  = ^{wdata[30:16], wdata[7:4]};

  // one storage slot per source; each slot is written by its own address match
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    logic hit_w;
    assign hit_w = wr_en && is_src_space && (addr[ADDR_W-2:0] == 7'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_pol[i]  <= 1'b1;
        cfg_trig[i] <= 1'b0;
        cfg_dual[i] <= 1'b0;
        cfg_en[i]   <= 1'b0;
        cfg_route[i*CORE_W +: CORE_W] <= '0;
      end else if (hit_w) begin
        cfg_pol[i]  <= wdata[B_POL];
        cfg_trig[i] <= wdata[B_TRIG];
        cfg_dual[i] <= wdata[B_DUAL];
        cfg_en[i]   <= wdata[B_EN];
        cfg_route[i*CORE_W +: CORE_W] <= wdata[B_ROUTE +: CORE_W];
      end
    end

    assign cmd_set[i] = is_cmd &&  wdata[B_RAISE] && (wdata[7:0] == 8'(i));
    assign cmd_clr[i] = is_cmd && !wdata[B_RAISE] && (wdata[7:0] == 8'(i));
  end

  always_comb begin
    rd_word = '0;
    if (addr == A_IDENT) begin
      rd_word = ident_word(NUM_SRC, NUM_CORE);
    end else if (is_src_space) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (addr[ADDR_W-2:0] == 7'(i)) begin
          rd_word[B_POL]  = cfg_pol[i];
          rd_word[B_TRIG] = cfg_trig[i];
          rd_word[B_DUAL] = cfg_dual[i];
          rd_word[B_EN]   = cfg_en[i];
          rd_word[B_ROUTE +: CORE_W] = cfg_route[i*CORE_W +: CORE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_word;
    end
  end

endmodule

// File: rtl/shint_src.sv
module shint_src #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] cfg_pol,
  input  logic [NUM_SRC-1:0] cfg_trig,
  input  logic [NUM_SRC-1:0] cfg_dual,
  input  logic [NUM_SRC-1:0] cmd_set,
  input  logic [NUM_SRC-1:0] cmd_clr,
  output logic [NUM_SRC-1:0] smp,
  output logic [NUM_SRC-1:0] smp_d,
  output logic [NUM_SRC-1:0] latch_q,
  output logic [NUM_SRC-1:0] pend
);

  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp   <= '0;
      smp_d <= '0;
    end else begin
      smp   <= irq_in;
      smp_d <= smp;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sense
    assign active[i] = cfg_pol[i] ? smp[i] : ~smp[i];
    always_comb begin
      if (cfg_dual[i]) begin
        hit[i] = smp[i] ^ smp_d[i];
      end else if (cfg_pol[i]) begin
        hit[i] = smp[i] & ~smp_d[i];
      end else begin
        hit[i] = ~smp[i] & smp_d[i];
      end
    end

    // a new edge or a software raise wins over an acknowledge in the same cycle
    always_ff @(posedge clk) begin
      if (rst) begin
        latch_q[i] <= 1'b0;
      end else if (cmd_set[i] || (cfg_trig[i] && hit[i])) begin
        latch_q[i] <= 1'b1;
      end else if (cmd_clr[i]) begin
        latch_q[i] <= 1'b0;
      end
    end

    assign pend[i] = latch_q[i] | (~cfg_trig[i] & active[i]);
  end

endmodule

// File: rtl/shint_pick.sv
module shint_pick #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2,
  parameter int CORE_W   = 1,
  parameter int IDX_W    = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         pend,
  input  logic [NUM_SRC-1:0]         cfg_en,
  input  logic [NUM_SRC*CORE_W-1:0]  cfg_route,
  output logic [NUM_CORE-1:0]        core_req,
  output logic [NUM_CORE*IDX_W-1:0]  core_idx
);

  localparam logic [IDX_W-1:0] IDLE = IDX_W'(NUM_SRC);

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    logic [NUM_SRC-1:0] qual;
    logic [IDX_W-1:0]   first;
    logic               any;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_q
      assign qual[i] = pend[i] & cfg_en[i] &
                       (cfg_route[i*CORE_W +: CORE_W] == CORE_W'(c));
    end

    always_comb begin
      first = IDLE;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (qual[i]) first = IDX_W'(i);
      end
    end

    assign any = |qual;

    always_ff @(posedge clk) begin
      if (rst) begin
        core_req[c] <= 1'b0;
        core_idx[c*IDX_W +: IDX_W] <= IDLE;
      end else begin
        core_req[c] <= any;
        core_idx[c*IDX_W +: IDX_W] <= first;
      end
    end
  end

endmodule

// File: rtl/shint_hub.sv
module shint_hub
  import shint_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2,
  localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
  localparam int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        irq_in,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [7:0]                addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic [NUM_CORE-1:0]       core_req,
  output logic [NUM_CORE*IDX_W-1:0] core_idx
);

  logic [NUM_SRC-1:0]        cfg_pol, cfg_trig, cfg_dual, cfg_en;
  logic [NUM_SRC*CORE_W-1:0] cfg_route;
  logic [NUM_SRC-1:0]        cmd_set, cmd_clr;
  logic [NUM_SRC-1:0]        smp, smp_d, latch_q, pend;

  shint_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .CORE_W(CORE_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cfg_pol(cfg_pol), .cfg_trig(cfg_trig),
    .cfg_dual(cfg_dual), .cfg_en(cfg_en), .cfg_route(cfg_route),
    .cmd_set(cmd_set), .cmd_clr(cmd_clr)
  );

  shint_src #(.NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_pol(cfg_pol),
    .cfg_trig(cfg_trig), .cfg_dual(cfg_dual), .cmd_set(cmd_set),
    .cmd_clr(cmd_clr), .smp(smp), .smp_d(smp_d), .latch_q(latch_q),
    .pend(pend)
  );

  shint_pick #(
    .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .CORE_W(CORE_W), .IDX_W(IDX_W)
  ) u_pick (
    .clk(clk), .rst(rst), .pend(pend), .cfg_en(cfg_en),
    .cfg_route(cfg_route), .core_req(core_req), .core_idx(core_idx)
  );

endmodule

// File: rtl/shint_chk.sv
module shint_chk #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2,
  parameter int IDX_W    = 5
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      rd_en,
  input logic [7:0]                addr,
  input logic [31:0]               rdata,
  input logic [NUM_CORE-1:0]       core_req,
  input logic [NUM_CORE*IDX_W-1:0] core_idx,
  input logic [NUM_SRC-1:0]        cmd_set,
  input logic [NUM_SRC-1:0]        cmd_clr,
  input logic [NUM_SRC-1:0]        cfg_trig,
  input logic [NUM_SRC-1:0]        cfg_dual,
  input logic [NUM_SRC-1:0]        smp,
  input logic [NUM_SRC-1:0]        smp_d,
  input logic [NUM_SRC-1:0]        latch_q
);

  localparam logic [IDX_W-1:0] IDLE = IDX_W'(NUM_SRC);
  localparam logic [31:0] IDENT = shint_pkg::ident_word(NUM_SRC, NUM_CORE);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_s
    // R1
    a_r1_raise_latches: assert property (@(posedge clk) disable iff (rst)
      cmd_set[i] |=> latch_q[i]);
    // R2
    a_r2_ack_clears: assert property (@(posedge clk) disable iff (rst)
      (cmd_clr[i] && !cmd_set[i] && !(cfg_trig[i] && (smp[i] != smp_d[i])))
      |=> !latch_q[i]);
    // R4
    a_r4_dual_any_edge: assert property (@(posedge clk) disable iff (rst)
      (cfg_trig[i] && cfg_dual[i] && (smp[i] != smp_d[i])) |=> latch_q[i]);
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_c
    // R6
    a_r6_req_matches_idx: assert property (@(posedge clk) disable iff (rst)
      core_req[c] == (core_idx[c*IDX_W +: IDX_W] != IDLE));
    // R6
    a_r6_idx_in_range: assert property (@(posedge clk) disable iff (rst)
      core_idx[c*IDX_W +: IDX_W] <= IDLE);
  end

  // R8
  a_r8_ident_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 8'h00) |=> rdata == IDENT);

endmodule

bind shint_hub shint_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .core_req(core_req), .core_idx(core_idx), .cmd_set(cmd_set),
  .cmd_clr(cmd_clr), .cfg_trig(cfg_trig), .cfg_dual(cfg_dual),
  .smp(smp), .smp_d(smp_d), .latch_q(latch_q)
);

// File: tb/tb_shint_hub.sv
`timescale 1ns/1ps
module tb_shint_hub;

  localparam int NS = 24;
  localparam int NC = 3;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] irq_in = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC-1:0] core_req;
  logic [NC*IW-1:0] core_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  shint_hub #(.NUM_SRC(NS), .NUM_CORE(NC)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .core_req(core_req),
    .core_idx(core_idx)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] d;
    logic [23:0] irq;
    logic [4:0]  e0, e1, e2;
  } vec_t;

  // sense word: bit0 pol, bit1 edge, bit2 dual, bit3 enable, bits[9:8] core
  localparam vec_t TBL [24] = '{
    '{8'h85, 32'h0009, 24'h000000, 5'd24, 5'd24, 5'd24}, // R6 nothing pending
    '{8'h02, 32'h0000, 24'h000020, 5'd5,  5'd24, 5'd24}, // R3 level high
    '{8'h82, 32'h0109, 24'h000024, 5'd5,  5'd2,  5'd24}, // R7 core 1
    '{8'h89, 32'h0009, 24'h000224, 5'd5,  5'd2,  5'd24}, // R6 lowest wins
    '{8'h02, 32'h0000, 24'h000204, 5'd9,  5'd2,  5'd24}, // R3 level drops
    '{8'h89, 32'h0001, 24'h000204, 5'd24, 5'd2,  5'd24}, // R6 disabled
    '{8'h82, 32'h0009, 24'h000204, 5'd2,  5'd24, 5'd24}, // R7 moved
    '{8'h82, 32'h0008, 24'h000204, 5'd24, 5'd24, 5'd24}, // R3 active low idle
    '{8'h02, 32'h0000, 24'h000200, 5'd2,  5'd24, 5'd24}, // R3 active low
    '{8'h82, 32'h000B, 24'h000200, 5'd24, 5'd24, 5'd24}, // R3 edge, no edge
    '{8'h02, 32'h0000, 24'h000204, 5'd2,  5'd24, 5'd24}, // R3 rise latches
    '{8'h02, 32'h0000, 24'h000200, 5'd2,  5'd24, 5'd24}, // R3 held
    '{8'h01, 32'h00000002, 24'h000200, 5'd24, 5'd24, 5'd24}, // R2 ack
    '{8'h01, 32'h80000011, 24'h000200, 5'd24, 5'd24, 5'd24}, // R1 raise masked
    '{8'h91, 32'h0209, 24'h000200, 5'd24, 5'd24, 5'd17}, // R1 raise seen
    '{8'h01, 32'h00000011, 24'h000200, 5'd24, 5'd24, 5'd24}, // R2 ack
    '{8'h94, 32'h010E, 24'h000200, 5'd24, 5'd24, 5'd24}, // R4 dual setup
    '{8'h02, 32'h0000, 24'h100200, 5'd24, 5'd20, 5'd24}, // R4 rise
    '{8'h01, 32'h00000014, 24'h100200, 5'd24, 5'd24, 5'd24}, // R2 ack
    '{8'h02, 32'h0000, 24'h000200, 5'd24, 5'd20, 5'd24}, // R4 fall
    '{8'h01, 32'h00000014, 24'h000200, 5'd24, 5'd24, 5'd24}, // R2 ack
    '{8'h02, 32'h0000, 24'h000220, 5'd5,  5'd24, 5'd24}, // R3 level
    '{8'h01, 32'h00000005, 24'h000220, 5'd5,  5'd24, 5'd24}, // R2 level stays
    '{8'h85, 32'h0309, 24'h000220, 5'd24, 5'd24, 5'd24}  // R7 no core
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic chk_core(string tag, int c, logic [4:0] e);
    chk(tag, {27'b0, core_idx[c*IW +: IW]}, {27'b0, e});
    chk(tag, {31'b0, core_req[c]}, {31'b0, (e != 5'd24)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R5 reset state
    for (int c = 0; c < NC; c++) chk_core("R5 reset outputs", c, 5'd24);
    rd(8'h80, d); chk("R5 reset sense word src0", d, 32'h1);
    rd(8'h97, d); chk("R5 reset sense word src23", d, 32'h1);
    // R8 identity
    rd(8'h00, d); chk("R8 identity word", d, 32'h0002_0002);

    foreach (TBL[k]) begin
      @(negedge clk);
      irq_in = TBL[k].irq;
      wr(TBL[k].a, TBL[k].d);
      settle();
      chk_core($sformatf("table step %0d core0", k), 0, TBL[k].e0);
      chk_core($sformatf("table step %0d core1", k), 1, TBL[k].e1);
      chk_core($sformatf("table step %0d core2", k), 2, TBL[k].e2);
    end

    // R9 readback of written fields, command address reads zero
    rd(8'h82, d); chk("R9 readback src2", d, 32'h0000_000B);
    rd(8'h94, d); chk("R9 readback src20", d, 32'h0000_010E);
    rd(8'h85, d); chk("R9 readback src5 route 3", d, 32'h0000_0309);
    rd(8'h01, d); chk("R9 command reads zero", d, 32'h0);

    // R3 edge active low: rising ignored, falling latches
    wr(8'h83, 32'h000A);
    @(negedge clk) irq_in = 24'h000228;
    settle();
    chk_core("R3 active-low edge ignores rise", 0, 5'd24);
    @(negedge clk) irq_in = 24'h000220;
    settle();
    chk_core("R3 active-low edge latches fall", 0, 5'd3);

    // R1 out-of-range raise touches nothing
    wr(8'h01, 32'h0000_0003);
    settle();
    chk_core("R2 ack src3", 0, 5'd24);
    wr(8'h01, 32'h8000_0018);
    settle();
    for (int c = 0; c < NC; c++) chk_core("R1 raise beyond range ignored", c, 5'd24);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule